// File: doc/BRIEF.md
# Raster Timing Generator with Shadowed Configuration

This block generates the scan timing for a parallel RGB panel. It produces a pixel clock and a matching pixel-advance strobe, horizontal and vertical sync, a data-enable strobe, and the current pixel and line positions that downstream pixel logic uses. The pixel clock runs at half the system clock. Each pixel position is held for two system cycles and advances when `pix_ce_o` is high.

The host writes eight timing fields through a small write-strobe port. These are the horizontal and vertical sync width, back porch, active size and front porch. Each write lands in a shadow copy that the counters do not use. A control write then moves the shadow set into the working set, in one of two ways. An immediate request copies on the next cycle and restarts the raster at pixel 0 of line 0. A blanking request waits until the last pixel of the last active line, so the new timing starts at pixel 0 of the next line. Both request bits clear themselves once the copy is done. A separate polarity register sets the output level of each sync, data-enable and clock signal. The status bits always report the logical state of the signals.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the counters and phase are 0, no reload is pending, the polarity register is 0 and the working and shadow sets hold the default parameters.
- R2: The system cycles alternate between phase 0 and phase 1. `pix_ce_o` shows the phase, and the pixel counter advances at the end of each phase-1 cycle. The pixel counter wraps to 0 after it reaches hsync+hbp+hact+hfp-1.
- R3: The line counter advances once each time the pixel counter wraps. It wraps to 0 after it reaches vsync+vbp+vact+vfp-1.
- R4: Logical horizontal sync is active while the pixel count is below the hsync width. Logical vertical sync is active while the line count is below the vsync width.
- R5: Logical data enable is active only when the pixel count is in [hsync+hbp, hsync+hbp+hact) and the line count is in [vsync+vbp, vsync+vbp+vact).
- R6: Polarity register bit 0 inverts hsync, bit 1 inverts vsync, bit 2 inverts data enable and bit 3 inverts the pixel clock (1 = active-low). A write to the polarity register takes effect on the next cycle.
- R7: The write addresses are: 0 hsync, 1 hbp, 2 hact, 3 hfp, 4 vsync, 5 vbp, 6 vact, 7 vfp (shadow fields), 8 polarity, 9 control. A write to a shadow field does not change the timing until a reload. Writes to addresses 10 to 15 have no effect.
- R8: Writing control bit 0 sets the immediate request (`reload_pend_o[0]`) on the next cycle. One cycle later the shadow set is copied, the counters and phase restart at 0, and both request bits clear.
- R9: Writing control bit 1 sets the blanking request (`reload_pend_o[1]`). The request stays set until the pixel counter wraps at the end of the last active line (line vsync+vbp+vact-1). At that point the shadow set is copied, the request clears and the new timing starts at pixel 0 of the next line.
- R10: `status_o` bit 0 is hsync, bit 1 is vsync and bit 2 is data enable. Each bit is 1 while its signal is logically active, whatever the polarity setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| pclk_o | output | 1 | Pixel clock, after polarity |
| pix_ce_o | output | 1 | High in the cycle that ends a pixel |
| hsync_o | output | 1 | Horizontal sync, after polarity |
| vsync_o | output | 1 | Vertical sync, after polarity |
| de_o | output | 1 | Data enable, after polarity |
| h_cnt_o | output | CW+2 | Current pixel position in the line |
| v_cnt_o | output | CW+2 | Current line position in the frame |
| status_o | output | 3 | Logical {de, vsync, hsync} |
| reload_pend_o | output | 2 | {blanking request, immediate request} |

## Verification
On every cycle, the assertions check four things. The pixel counter stays inside the working line length. Data enable never overlaps a sync pulse. The counters hold in phase-0 cycles. The working timing changes only where the pixel counter is 0. They also check that the immediate request lasts a single cycle and that the blanking request stays set until its boundary.

Some behaviour only the bench scenarios can show. These are the exact wrap points under each timing set, the output inversion for each polarity pattern, and that shadow writes are ignored until a reload. They also include the line on which a deferred reload lands and that writes to unused addresses do nothing.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CW = 10,
  parameter int TW = CW + 2,
  parameter logic [CW-1:0] D_HSW = 1,
  parameter logic [CW-1:0] D_HBP = 1,
  parameter logic [CW-1:0] D_HACT = 2,
  parameter logic [CW-1:0] D_HFP = 1,
  parameter logic [CW-1:0] D_VSW = 1,
  parameter logic [CW-1:0] D_VBP = 1,
  parameter logic [CW-1:0] D_VACT = 2,
  parameter logic [CW-1:0] D_VFP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [15:0]   wr_data,
  output logic          pclk_o,
  output logic          pix_ce_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [TW-1:0] h_cnt_o,
  output logic [TW-1:0] v_cnt_o,
  output logic [2:0]    status_o,
  output logic [1:0]    reload_pend_o
);

  localparam int NF = 8;

  function automatic logic [CW-1:0] dflt(input int i);
    case (i)
      0: dflt = D_HSW;
      1: dflt = D_HBP;
      2: dflt = D_HACT;
      3: dflt = D_HFP;
      4: dflt = D_VSW;
      5: dflt = D_VBP;
      6: dflt = D_VACT;
      default: dflt = D_VFP;
    endcase
  endfunction

  logic [CW-1:0] shd [NF];
  logic [CW-1:0] wrk [NF];
  logic [3:0]    pol;
  logic          imm_q, blk_q, ph;
  logic [TW-1:0] h, v;

  wire [TW-1:0] htot     = TW'(wrk[0]) + TW'(wrk[1]) + TW'(wrk[2]) + TW'(wrk[3]);
  wire [TW-1:0] vtot     = TW'(wrk[4]) + TW'(wrk[5]) + TW'(wrk[6]) + TW'(wrk[7]);
  wire [TW-1:0] vtot_shd = TW'(shd[4]) + TW'(shd[5]) + TW'(shd[6]) + TW'(shd[7]);
  wire [TW-1:0] hde0     = TW'(wrk[0]) + TW'(wrk[1]);
  wire [TW-1:0] vde0     = TW'(wrk[4]) + TW'(wrk[5]);
  wire [TW-1:0] vlast    = vde0 + TW'(wrk[6]) - 1'b1;
  wire          eol      = ph && (h >= htot - 1'b1);
  wire          hs = h < TW'(wrk[0]);
  wire          vs = v < TW'(wrk[4]);
  wire          de = (h >= hde0) && (h < hde0 + TW'(wrk[2])) &&
                     (v >= vde0) && (v < vde0 + TW'(wrk[6]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        shd[i] <= dflt(i);
        wrk[i] <= dflt(i);
      end
      pol <= '0; imm_q <= 1'b0; blk_q <= 1'b0; ph <= 1'b0;
      h <= '0; v <= '0;
    end else begin
      if (imm_q) begin
        for (int i = 0; i < NF; i++) wrk[i] <= shd[i];
        h <= '0; v <= '0; ph <= 1'b0;
        imm_q <= 1'b0; blk_q <= 1'b0;
      end else begin
        ph <= ~ph;
        if (eol) begin
          h <= '0;
          if (blk_q && v == vlast) begin
            for (int i = 0; i < NF; i++) wrk[i] <= shd[i];
            blk_q <= 1'b0;
            v <= (v >= vtot_shd - 1'b1) ? '0 : v + 1'b1;
          end else begin
            v <= (v >= vtot - 1'b1) ? '0 : v + 1'b1;
          end
        end else if (ph) begin
          h <= h + 1'b1;
        end
      end
      if (wr_en) begin
        if (wr_addr < 4'(NF)) shd[wr_addr[2:0]] <= wr_data[CW-1:0];
        else if (wr_addr == 4'd8) pol <= wr_data[3:0];
        else if (wr_addr == 4'd9) begin
          if (wr_data[0]) imm_q <= 1'b1;
          if (wr_data[1]) blk_q <= 1'b1;
        end
      end
    end
  end

  assign pclk_o        = ph ^ pol[3];
  assign pix_ce_o      = ph;
  assign hsync_o       = hs ^ pol[0];
  assign vsync_o       = vs ^ pol[1];
  assign de_o          = de ^ pol[2];
  assign h_cnt_o       = h;
  assign v_cnt_o       = v;
  assign status_o      = {de, vs, hs};
  assign reload_pend_o = {blk_q, imm_q};

  assert_h_in_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    h < htot);
  assert_de_outside_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hs && !vs));
  assert_hold_in_phase0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph && !imm_q) |=> $stable(h) && $stable(v));
  assert_cfg_at_line_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(htot) |-> h == '0);
  assert_imm_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    imm_q |=> (!imm_q || $past(wr_en && wr_addr == 4'd9 && wr_data[0])));
  assert_blk_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && !imm_q && !(eol && v == vlast)) |=> blk_q);

endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int CW = 10;
  localparam int TW = CW + 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pclk_o, pix_ce_o, hsync_o, vsync_o, de_o;
  logic [TW-1:0] h_cnt_o, v_cnt_o;
  logic [2:0] status_o;
  logic [1:0] reload_pend_o;

  raster_timing_gen #(.CW(CW)) i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pclk_o(pclk_o), .pix_ce_o(pix_ce_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .h_cnt_o(h_cnt_o), .v_cnt_o(v_cnt_o), .status_o(status_o),
    .reload_pend_o(reload_pend_o));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int sh[8] = '{1,1,2,1,1,1,2,1};
  int wk[8] = '{1,1,2,1,1,1,2,1};
  int pol = 0, mh = 0, mv = 0, mph = 0, imm = 0, blk = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_step();
    int htot = wk[0]+wk[1]+wk[2]+wk[3];
    int vtot = wk[4]+wk[5]+wk[6]+wk[7];
    int vlast = wk[4]+wk[5]+wk[6]-1;
    if (imm != 0) begin
      wk = sh; mh = 0; mv = 0; mph = 0; imm = 0; blk = 0;
    end else begin
      if (mph == 1) begin
        if (mh >= htot-1) begin
          mh = 0;
          if (blk != 0 && mv == vlast) begin
            wk = sh; blk = 0;
            vtot = wk[4]+wk[5]+wk[6]+wk[7];
          end
          mv = (mv >= vtot-1) ? 0 : mv+1;
        end else mh = mh + 1;
      end
      mph = 1 - mph;
    end
    if (wr_en) begin
      if (wr_addr < 8) sh[wr_addr] = int'(wr_data[CW-1:0]);
      else if (wr_addr == 8) pol = int'(wr_data[3:0]);
      else if (wr_addr == 9) begin
        if (wr_data[0]) imm = 1;
        if (wr_data[1]) blk = 1;
      end
    end
  endtask

  task automatic compare();
    int hs = (mh < wk[0]) ? 1 : 0;
    int vs = (mv < wk[4]) ? 1 : 0;
    int de = (mh >= wk[0]+wk[1] && mh < wk[0]+wk[1]+wk[2] &&
              mv >= wk[4]+wk[5] && mv < wk[4]+wk[5]+wk[6]) ? 1 : 0;
    chk("R2 pixel count", int'(h_cnt_o), mh);
    chk("R2 pix_ce", int'(pix_ce_o), mph);
    chk("R3 line count", int'(v_cnt_o), mv);
    chk("R4 R6 hsync pin", int'(hsync_o), hs ^ (pol & 1));
    chk("R4 R6 vsync pin", int'(vsync_o), vs ^ ((pol >> 1) & 1));
    chk("R5 R6 de pin", int'(de_o), de ^ ((pol >> 2) & 1));
    chk("R6 pclk pin", int'(pclk_o), mph ^ ((pol >> 3) & 1));
    chk("R10 status", int'(status_o), de*4 + vs*2 + hs);
    chk("R8 R9 pending", int'(reload_pend_o), blk*2 + imm);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    compare();                       // R1 reset state
    rst_n = 1'b1;
    run(30);                         // R2 R3 R4 R5 default timing
    // R7: shadow writes, config A, no effect yet
    wr(0, 2); wr(1, 1); wr(2, 4); wr(3, 1);
    wr(4, 1); wr(5, 1); wr(6, 3); wr(7, 1);
    run(40);
    wr(9, 1);                        // R8 immediate reload
    run(200);
    wr(8, 15);                       // R6 all active-low
    run(120);
    wr(8, 5);
    run(60);
    wr(12, 16'hffff); wr(15, 3);     // R7 unused addresses
    run(40);
    wr(8, 0);
    // R9 config B, then blanking reload
    wr(0, 1); wr(1, 2); wr(2, 3); wr(3, 1);
    wr(4, 2); wr(5, 1); wr(6, 2); wr(7, 1);
    run(7);
    wr(9, 2);
    run(260);
    wr(9, 2);                        // R9 request for an unchanged set
    run(120);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule